// File: doc/BRIEF.md
# XTS Tweak Sequence Generator

This block supplies the per-block tweak values for a storage cipher that runs in XTS mode. It is loaded with a 128-bit starting tweak, which is the IV after encryption. It then holds a group of `LANES` consecutive tweaks, one for each of up to four cipher datapaths running side by side. Lane k always holds the first tweak of the group multiplied by x^k in GF(2^128).

A group advance moves every lane forward by x^LANES in one cycle. The bits shifted out of the top of each lane are folded back into its low end with a carry-less multiply by the reduction constant, so lane 0 of the new group follows straight on from the last lane of the old group. A single-step advance moves the sequence on by exactly one block, which is how leftover blocks at the end of a job are handled. The `next_tweak` output always shows the first tweak that the current group does not use, so a multi-part job can save it and later resume from it.

Top module: `xts_tweak_gen`

## Requirements
- R1: After reset, `valid` is 0 and all lanes and `next_tweak` read zero.
- R2: One cycle after `load`, lane k equals `init_tweak` multiplied by x^k, and `valid` is 1 for that cycle.
- R3: Multiplying by x is a 1-bit left shift of the 128-bit value, with byte 0 in bits 7:0, so bit 63 carries into bit 64. When bit 127 is shifted out, 0x87 is XORed into bits 7:0 (for example, 2^127 times x gives 0x87).
- R4: One cycle after a group advance, every lane has been multiplied by x^LANES, so the new lane 0 equals the old last lane times x.
- R5: One cycle after a single advance, lane 0 equals the old lane 0 times x, and lane k equals the new lane 0 times x^k.
- R6: `next_tweak` always equals the last lane times x, which is the first tweak after the group.
- R7: When `load` is asserted in the same cycle as an advance, the load wins and the advance has no effect.
- R8: `valid` is 1 only in the cycle after a load or an accepted advance. In an idle cycle `valid` is 0 and all lanes hold their values.
- R9: Advances requested before the first load are ignored: the lanes stay zero and `valid` stays 0.
- R10: When both advances are requested in the same cycle, the group advance is the one performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Take `init_tweak` as the new lane 0 |
| init_tweak | input | 128 | Starting tweak, byte 0 in bits 7:0 |
| adv_group | input | 1 | Advance all lanes by x^LANES |
| adv_one | input | 1 | Advance the sequence by one block |
| lanes_out | output | 128*LANES | Lane k in bits 128k+127 down to 128k |
| next_tweak | output | 128 | First tweak after the group, to save for continuation |
| valid | output | 1 | High for one cycle after an update |

## Verification
A wrong reduction term or a wrong shift shows up in the cycle right after the load or advance that uses it. It appears as a difference in some lane, but only when a top bit of that lane was set. For this reason the sweep loads all sixteen combinations of the top four bits and then advances several times. An error in lane ordering, or in how lane 0 is rebuilt after a single step, breaks the lane-to-lane x relation on the very next update. A wrong priority or a wrong handling of the loaded state changes the lanes or `valid` in the cycle that follows the conflicting request.

// File: rtl/xts_tweak_gen.sv
module xts_tweak_gen #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [127:0]         init_tweak,
  input  logic                 adv_group,
  input  logic                 adv_one,
  output logic [LANES*128-1:0] lanes_out,
  output logic [127:0]         next_tweak,
  output logic                 valid
);
  localparam int W   = 128;
  localparam int RW  = LANES + 8;

  function automatic logic [W-1:0] times_x(input logic [W-1:0] t);
    return {t[W-2:0], 1'b0} ^ ({{(W-8){1'b0}}, 8'h87} & {W{t[W-1]}});
  endfunction

  function automatic logic [W-1:0] times_xn(input logic [W-1:0] t);
    logic [LANES-1:0] spill;
    logic [RW-1:0]    fold;
    spill = t[W-1 -: LANES];
    fold  = '0;
    for (int i = 0; i < LANES; i++)
      if (spill[i]) fold = fold ^ (RW'(8'h87) << i);
    return (t << LANES) ^ {{(W-RW){1'b0}}, fold};
  endfunction

  logic [W-1:0] lane_q [LANES];
  logic [W-1:0] chain  [LANES];
  logic         loaded_q;
  logic         do_rebuild, do_group;

  assign do_rebuild = load | (loaded_q & adv_one & ~adv_group);
  assign do_group   = ~load & loaded_q & adv_group;
  assign chain[0]   = load ? init_tweak : times_x(lane_q[0]);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k > 0) begin : g_chain
      assign chain[k] = times_x(chain[k-1]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n)          lane_q[k] <= '0;
      else if (do_rebuild) lane_q[k] <= chain[k];
      else if (do_group)   lane_q[k] <= times_xn(lane_q[k]);
    end
    assign lanes_out[k*W +: W] = lane_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      valid    <= 1'b0;
    end else begin
      loaded_q <= loaded_q | load;
      valid    <= load | (loaded_q & (adv_group | adv_one));
    end
  end

  assign next_tweak = times_x(lane_q[LANES-1]);
endmodule

module xts_tweak_gen_chk #(
  parameter int LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load,
  input logic [127:0]         init_tweak,
  input logic                 adv_group,
  input logic                 adv_one,
  input logic [LANES*128-1:0] lanes_out,
  input logic [127:0]         next_tweak,
  input logic                 valid,
  input logic                 loaded_q
);
  function automatic logic [127:0] mx(input logic [127:0] t);
    logic [128:0] s;
    s = {t, 1'b0};
    return s[128] ? (s[127:0] ^ 128'h87) : s[127:0];
  endfunction

  assert_load_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lanes_out[127:0] == $past(init_tweak)) && valid);

  assert_group_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && loaded_q && adv_group) |=> lanes_out[127:0] == mx($past(lanes_out[LANES*128-1 -: 128])));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && loaded_q && adv_one && !adv_group) |=> lanes_out[127:0] == mx($past(lanes_out[127:0])));

  assert_next_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    next_tweak == mx(lanes_out[LANES*128-1 -: 128]));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_group && !adv_one) |=> $stable(lanes_out) && !valid);

  assert_unloaded_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded_q && !load) |=> !valid && lanes_out == '0);
endmodule

bind xts_tweak_gen xts_tweak_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .init_tweak(init_tweak),
  .adv_group(adv_group), .adv_one(adv_one), .lanes_out(lanes_out),
  .next_tweak(next_tweak), .valid(valid), .loaded_q(loaded_q)
);

// File: tb/xts_tweak_gen_test.sv
module xts_tweak_gen_test;
  localparam int N = 4;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           load = 0, adv_group = 0, adv_one = 0;
  logic [127:0]   init_tweak = '0;
  logic [N*128-1:0] lanes_out;
  logic [127:0]   next_tweak;
  logic           valid;

  int total = 0, bad = 0, cycles = 0;
  logic [127:0] m0 = '0;
  logic         m_loaded = 0;

  xts_tweak_gen #(.LANES(N)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .init_tweak(init_tweak),
    .adv_group(adv_group), .adv_one(adv_one), .lanes_out(lanes_out),
    .next_tweak(next_tweak), .valid(valid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [127:0] mx(input logic [127:0] t);
    logic [128:0] s;
    s = {t, 1'b0};
    return s[128] ? (s[127:0] ^ 128'h87) : s[127:0];
  endfunction

  function automatic logic [127:0] mxk(input logic [127:0] t, input int k);
    logic [127:0] r = t;
    for (int i = 0; i < k; i++) r = mx(r);
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp_valid);
    for (int k = 0; k < N; k++) check(req, lanes_out[k*128 +: 128], mxk(m0, k));
    check({req, "/R6"}, next_tweak, mxk(m0, N));
    check({req, "/R8"}, {127'b0, valid}, {127'b0, exp_valid});
  endtask

  task automatic step(input logic l, input logic [127:0] v, input logic g, input logic o);
    @(negedge clk);
    load = l; init_tweak = v; adv_group = g; adv_one = o;
    @(negedge clk);
    load = 0; adv_group = 0; adv_one = 0;
    if (l) begin m0 = v; m_loaded = 1; end
    else if (m_loaded && g) m0 = mxk(m0, N);
    else if (m_loaded && o) m0 = mx(m0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1", 1'b0);
    rst_n = 1;
    step(0, '0, 1, 0); check_all("R9", 1'b0);
    step(0, '0, 0, 1); check_all("R9", 1'b0);
    step(1, 128'h1 << 127, 0, 0);
    check("R3", lanes_out[255:128], 128'h87);
    step(1, 128'h01, 0, 0);
    check("R3", lanes_out[255:128], 128'h02);
    step(1, 128'h8000_0000_0000_0000, 0, 0);
    check("R3", lanes_out[255:128], 128'h1_0000_0000_0000_0000);
    for (int top = 0; top < 16; top++) begin
      step(1, {top[3:0], 124'h5a3c_96e1_0f27_d48b_7e19_c3a6_2b5}, 0, 0);
      check_all("R2", 1'b1);
      for (int g = 0; g < 3; g++) begin
        step(0, '0, 1, 0); check_all("R4", 1'b1);
      end
      step(0, '0, 0, 1); check_all("R5", 1'b1);
      step(0, '0, 0, 0); check_all("R8", 1'b0);
    end
    for (int i = 0; i < 40; i++) begin
      step(0, '0, 0, 1); check_all("R5", 1'b1);
    end
    step(1, 128'hdead_beef_0123_4567_89ab_cdef_f00d_cafe, 1, 1);
    check_all("R7", 1'b1);
    step(1, 128'hffff_0000_ffff_0000_ffff_0000_ffff_0000, 0, 1);
    check_all("R7", 1'b1);
    step(0, '0, 1, 1); check_all("R10", 1'b1);
    step(0, '0, 0, 0); check_all("R8", 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule